// File: doc/BRIEF.md
# Speed-up Charge Pump Current Controller

This block produces the digital current-scaling codes for a synthesiser's main (proportional) charge pump and for a second pump that feeds the integrating capacitor of the loop filter. In normal running, the proportional code equals the base multiplier CN, and the second pump is disabled with a zero code. The analog side turns each code into a current. One code unit is a reference current: the current through an external bias resistor, divided by 32.

Every time a channel word is loaded, the load strobe goes high and the block enters speed-up. While the strobe stays high, the proportional code is CN multiplied by 2^(L+1), which is a gain of 2, 4, 8 or 16 for a 2-bit L. The second pump is enabled at K times that boosted code. Speed-up has no timer. It lasts exactly as long as the strobe. Normal codes return on the first clock edge after the strobe falls. To make the effect negligible, software keeps the strobe short and sets L and K to their minimum values.

All three outputs are registered from one sampled set of inputs. A mode change therefore reaches every output on the same edge, with no mixed intermediate state.

Top module: `cp_speedup_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, prop_code and aux_code are cleared to 0 and aux_en is cleared to 0 at that edge.
- R2: When load_stb is sampled low at an edge, prop_code equals the cn value sampled at that same edge.
- R3: When load_stb is sampled high at an edge, prop_code equals cn * 2^(spd_l + 1), with spd_l taken as an unsigned 2-bit value.
- R4: aux_en is 1 exactly after edges where load_stb was sampled high, and 0 after edges where it was sampled low.
- R5: When load_stb is sampled high, aux_code equals spd_k (unsigned, 3 bits) times the boosted proportional code. When load_stb is sampled low, aux_code is 0.
- R6: After the strobe falls, normal codes appear on the very first edge at which load_stb is sampled low. While the strobe stays high, the codes follow changes of cn, spd_l and spd_k edge by edge.
- R7: prop_code is 12 bits wide and aux_code is 15 bits wide, so that cn = 255 with spd_l = 3 and spd_k = 7 gives 4080 and 28560 with no truncation.
- R8: All outputs change on the same edge. aux_code and prop_code always come from the same sampled inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_stb | input | 1 | Channel-word load strobe; high selects speed-up |
| cn | input | 8 | Base proportional multiplier |
| spd_l | input | 2 | Speed-up gain exponent (gain 2^(L+1)) |
| spd_k | input | 3 | Second-pump ratio |
| prop_code | output | 12 | Proportional pump current code |
| aux_code | output | 15 | Integral-path pump current code |
| aux_en | output | 1 | Integral-path pump enable |

## Verification
Each output is due exactly one rising edge after the inputs that produce it are sampled. Inputs are applied on the falling edge, and the outputs are read on the next falling edge, so every check lines up with the single register stage. The sweep covers every cn, spd_l and spd_k value with the strobe high, and every cn value with the strobe low. Strobe-fall checks read the outputs on the first falling edge after the strobe is sampled low. This confirms that no boosted value lingers for an extra cycle.

// File: rtl/cp_speedup_pkg.sv
// Shared definitions for the speed-up charge pump controller.
// Assumes: default widths are used unless the top module overrides them.
package cp_speedup_pkg;
    localparam int unsigned CN_W_DEF = 8;
    localparam int unsigned L_W_DEF  = 2;
    localparam int unsigned K_W_DEF  = 3;

    typedef enum logic {
        PUMP_NORMAL = 1'b0,
        PUMP_BOOST  = 1'b1
    } pump_mode_e;
endpackage

// File: rtl/cp_boost_shift.sv
// Selects the proportional code: cn in normal mode, or cn shifted left by
// (l + 1) in boost mode.
// Assumes: OUT_W >= CN_W + 2**L_W, so the largest shift never overflows.
module cp_boost_shift
    import cp_speedup_pkg::*;
#(
    parameter int unsigned CN_W  = CN_W_DEF,
    parameter int unsigned L_W   = L_W_DEF,
    parameter int unsigned OUT_W = CN_W + (1 << L_W)
) (
    input  pump_mode_e        mode,
    input  logic [CN_W-1:0]   cn,
    input  logic [L_W-1:0]    l,
    output logic [OUT_W-1:0]  code
);
    localparam int unsigned NUM_GAIN = 1 << L_W;

    logic [OUT_W-1:0] cand [NUM_GAIN];

    // One candidate per gain setting.
    for (genvar i = 0; i < NUM_GAIN; i++) begin : g_gain
        assign cand[i] = OUT_W'(cn) << (i + 1);
    end

    // Picks the normal or the boosted code.
    always_comb begin
        if (mode == PUMP_BOOST) begin
            code = cand[l];
        end else begin
            code = OUT_W'(cn);
        end
    end
endmodule

// File: rtl/cp_aux_scale.sv
// Derives the enable and the code of the integral-path pump from the
// proportional code: K times that code in boost mode, and off otherwise.
// Assumes: OUT_W >= IN_W + K_W.
module cp_aux_scale
    import cp_speedup_pkg::*;
#(
    parameter int unsigned IN_W  = 12,
    parameter int unsigned K_W   = K_W_DEF,
    parameter int unsigned OUT_W = IN_W + K_W
) (
    input  pump_mode_e        mode,
    input  logic [IN_W-1:0]   prop_in,
    input  logic [K_W-1:0]    k,
    output logic              en,
    output logic [OUT_W-1:0]  code
);
    // The second pump runs only in boost mode.
    always_comb begin
        if (mode == PUMP_BOOST) begin
            en   = 1'b1;
            code = OUT_W'(prop_in) * OUT_W'(k);
        end else begin
            en   = 1'b0;
            code = '0;
        end
    end
endmodule

// File: rtl/cp_code_reg.sv
// Output register stage. All codes update together on one edge.
// Assumes: synchronous active-low reset.
module cp_code_reg #(
    parameter int unsigned PROP_W = 12,
    parameter int unsigned AUX_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PROP_W-1:0] prop_d,
    input  logic [AUX_W-1:0]  aux_d,
    input  logic              en_d,
    output logic [PROP_W-1:0] prop_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic              en_q
);
    // Captures the complete code set, or clears it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prop_q <= '0;
            aux_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            prop_q <= prop_d;
            aux_q  <= aux_d;
            en_q   <= en_d;
        end
    end
endmodule

// File: rtl/cp_speedup_ctrl.sv
// Top level of the speed-up charge pump controller. The load strobe selects
// boost mode directly. The codes are computed combinationally and then
// registered once.
// Assumes: the strobe is synchronous to clk.
module cp_speedup_ctrl
    import cp_speedup_pkg::*;
#(
    parameter int unsigned CN_W = CN_W_DEF,
    parameter int unsigned L_W  = L_W_DEF,
    parameter int unsigned K_W  = K_W_DEF,
    localparam int unsigned PROP_W = CN_W + (1 << L_W),
    localparam int unsigned AUX_W  = PROP_W + K_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [CN_W-1:0]   cn,
    input  logic [L_W-1:0]    spd_l,
    input  logic [K_W-1:0]    spd_k,
    output logic [PROP_W-1:0] prop_code,
    output logic [AUX_W-1:0]  aux_code,
    output logic              aux_en
);
    pump_mode_e        mode;
    logic [PROP_W-1:0] prop_d;
    logic [AUX_W-1:0]  aux_d;
    logic              en_d;

    // The strobe level is the mode; there is no timer.
    assign mode = load_stb ? PUMP_BOOST : PUMP_NORMAL;

    cp_boost_shift #(.CN_W(CN_W), .L_W(L_W), .OUT_W(PROP_W)) u_shift (
        .mode (mode),
        .cn   (cn),
        .l    (spd_l),
        .code (prop_d)
    );

    cp_aux_scale #(.IN_W(PROP_W), .K_W(K_W), .OUT_W(AUX_W)) u_aux (
        .mode    (mode),
        .prop_in (prop_d),
        .k       (spd_k),
        .en      (en_d),
        .code    (aux_d)
    );

    cp_code_reg #(.PROP_W(PROP_W), .AUX_W(AUX_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .prop_d (prop_d),
        .aux_d  (aux_d),
        .en_d   (en_d),
        .prop_q (prop_code),
        .aux_q  (aux_code),
        .en_q   (aux_en)
    );
endmodule

// File: rtl/cp_speedup_chk.sv
// Checker for cp_speedup_ctrl. It relates the sampled inputs to the outputs
// one edge later, and it is attached to the top module with a bind statement.
module cp_speedup_chk #(
    parameter int unsigned CN_W = 8,
    parameter int unsigned L_W  = 2,
    parameter int unsigned K_W  = 3,
    localparam int unsigned PROP_W = CN_W + (1 << L_W),
    localparam int unsigned AUX_W  = PROP_W + K_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_stb,
    input logic [CN_W-1:0]   cn,
    input logic [L_W-1:0]    spd_l,
    input logic [K_W-1:0]    spd_k,
    input logic [PROP_W-1:0] prop_code,
    input logic [AUX_W-1:0]  aux_code,
    input logic              aux_en
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (prop_code == '0 && aux_code == '0 && !aux_en)); // R1
    AST_NORMAL_CODE: assert property (@(posedge clk) disable iff (!rst_n) !load_stb |=> prop_code == PROP_W'($past(cn))); // R2
    AST_BOOST_CODE:  assert property (@(posedge clk) disable iff (!rst_n) load_stb |=> prop_code == (PROP_W'($past(cn)) << ($past(spd_l) + 1))); // R3
    AST_AUX_ON:      assert property (@(posedge clk) disable iff (!rst_n) load_stb |=> aux_en); // R4
    AST_AUX_OFF:     assert property (@(posedge clk) disable iff (!rst_n) !load_stb |=> (!aux_en && aux_code == '0)); // R5
    AST_FALL_RETURN: assert property (@(posedge clk) disable iff (!rst_n) $fell(load_stb) |=> (!aux_en && prop_code == PROP_W'($past(cn)))); // R6
    AST_AUX_RATIO:   assert property (@(posedge clk) disable iff (!rst_n) aux_en |-> aux_code == AUX_W'(prop_code) * AUX_W'($past(spd_k))); // R8
endmodule

bind cp_speedup_ctrl cp_speedup_chk #(.CN_W(CN_W), .L_W(L_W), .K_W(K_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .cn        (cn),
    .spd_l     (spd_l),
    .spd_k     (spd_k),
    .prop_code (prop_code),
    .aux_code  (aux_code),
    .aux_en    (aux_en)
);

// File: tb/tb_cp_speedup_ctrl.sv
// Bench for cp_speedup_ctrl. It sweeps every input value and computes the
// expected codes arithmetically.
module tb_cp_speedup_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [7:0]  cn = '0;
    logic [1:0]  spd_l = '0;
    logic [2:0]  spd_k = '0;
    logic [11:0] prop_code;
    logic [14:0] aux_code;
    logic        aux_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cp_speedup_ctrl dut (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .cn(cn),
        .spd_l(spd_l), .spd_k(spd_k),
        .prop_code(prop_code), .aux_code(aux_code), .aux_en(aux_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives inputs after a falling edge; the result is read at the next falling edge.
    task automatic step(input bit s, input int c, input int l, input int k);
        load_stb = s; cn = 8'(c); spd_l = 2'(l); spd_k = 3'(k);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_codes(input string tag, input bit s, input int c, input int l, input int k);
        int p;
        p = s ? c * (1 << (l + 1)) : c;
        chk({tag, " prop"}, int'(prop_code), p);
        chk({tag, " aux"}, int'(aux_code), s ? p * k : 0);
        chk({tag, " en"}, int'(aux_en), int'(s));
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 200, 3, 7);
        // R1: reset clears every output even with the strobe high
        chk("R1 prop", int'(prop_code), 0);
        chk("R1 aux", int'(aux_code), 0);
        chk("R1 en", int'(aux_en), 0);
        rst_n = 1'b1;
        // R2: normal mode, every cn value
        for (int c = 0; c < 256; c++) begin
            step(1'b0, c, c % 4, c % 8);
            expect_codes("R2", 1'b0, c, c % 4, c % 8);
        end
        // R3 R5 R4: boost mode, exhaustive over cn, l and k
        for (int c = 0; c < 256; c++) begin
            for (int l = 0; l < 4; l++) begin
                for (int k = 0; k < 8; k++) begin
                    step(1'b1, c, l, k);
                    expect_codes("R3_R5", 1'b1, c, l, k);
                end
            end
        end
        // R7: largest values without truncation
        step(1'b1, 255, 3, 7);
        chk("R7 prop", int'(prop_code), 4080);
        chk("R7 aux", int'(aux_code), 28560);
        // R6: strobe falls, so normal codes are due on the first edge
        step(1'b0, 255, 3, 7);
        expect_codes("R6 fall", 1'b0, 255, 3, 7);
        // R6: a long strobe follows input changes edge by edge
        step(1'b1, 10, 0, 1);
        expect_codes("R6 hold", 1'b1, 10, 0, 1);
        step(1'b1, 11, 2, 3);
        expect_codes("R6 hold", 1'b1, 11, 2, 3);
        step(1'b1, 12, 1, 0);
        expect_codes("R8 k0", 1'b1, 12, 1, 0);
        step(1'b0, 13, 1, 5);
        expect_codes("R6 fall", 1'b0, 13, 1, 5);
        // R4: a single-cycle strobe gives exactly one boosted cycle
        step(1'b1, 3, 0, 0);
        expect_codes("R4 short", 1'b1, 3, 0, 0);
        step(1'b0, 3, 0, 0);
        expect_codes("R4 short", 1'b0, 3, 0, 0);
        // R1: reset in the middle of a strobe
        rst_n = 1'b0;
        step(1'b1, 99, 2, 4);
        chk("R1 mid prop", int'(prop_code), 0);
        chk("R1 mid en", int'(aux_en), 0);
        rst_n = 1'b1;
        step(1'b1, 99, 2, 4);
        expect_codes("R8 after reset", 1'b1, 99, 2, 4);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule